// File: doc/BRIEF.md
# Synchronous Domain Clock Enable Generator

This block produces the clock enables for four synchronous domains: processor core (CPU), high-speed bus (HSB) and two peripheral buses (PBA, PBB). All four come from a common main clock. Clocks are modelled as one-cycle enable strobes on a fast reference clock. The main clock is the strobe of one of three sources: a slow clock, oscillator 0 or PLL0. The oscillators and PLLs themselves are outside the block. Each one appears only as a tick strobe and a ready or lock flag.

An 8-bit prescaler counts main-clock ticks. Each domain takes either the undivided main clock or one prescaler tap. Software writes the source code and a 32-bit divider word through a small write port. The block rejects a source change to a source that is not ready, and it rejects a divider word that would make the CPU slower than either peripheral bus. An accepted setting waits in a pending register and becomes active only when the prescaler wraps, so no strobe is ever cut short.

A sleep level stops whole domains. Per-module mask inputs gate single module enables inside a domain. A rising edge on any PLL lock flag raises a one-cycle interrupt strobe.

Top module: `sync_clk_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `act_src_o` reads 0 (slow clock), `act_div_o` reads 0 (all domains undivided) and every enable and interrupt output is low.
- R2: The source codes are 0 = slow clock, 1 = oscillator 0 and 2 = PLL0. The main tick is the tick input of the active source, and a domain with an undivided setting strobes once for every such tick.
- R3: A source write (`cfg_addr_i`=0, code in `cfg_wdata_i[1:0]`) is ignored when the code is 3, when the code is 1 and `osc0_rdy_i` is low, or when the code is 2 and `pll_lock_i[0]` is low.
- R4: The divider word holds one byte per domain: CPU in bits 7:0, HSB in 15:8, PBA in 23:16 and PBB in 31:24. In each byte, bit 7 high selects tap `bits[2:0]`, which divides the main tick rate by 2^(tap+1). Bit 7 low selects the undivided main tick. Bits 6:3, and the tap bits when bit 7 is low, have no effect on the rate.
- R5: A divider write (`cfg_addr_i`=1) is rejected, and the previous setting kept, when the CPU division exponent (0 if undivided, tap+1 otherwise) is larger than that of PBA or of PBB. HSB is not constrained.
- R6: Accepted settings become active only on a main tick at which the prescaler wraps from 255 to 0. A write accepted in that same cycle is applied at that wrap. Without main ticks, nothing is applied.
- R7: Sleep level 1 stops the CPU. Level 2 also stops HSB. Level 3 stops all four domains. A change takes effect on the next enable.
- R8: Module enable `mod_en_o[d*MODS+m]` follows domain d's enable and is held low while `mod_mask_i[d*MODS+m]` is high.
- R9: A 0-to-1 change of `pll_lock_i[i]` gives exactly one high cycle on `lock_irq_o[i]`, one cycle later. A steady or falling lock flag gives none.
- R10: The enable outputs are registered and go high in the cycle after the main tick that produces them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick_i | input | 1 | Slow clock strobe |
| osc0_tick_i | input | 1 | Oscillator 0 strobe |
| pll0_tick_i | input | 1 | PLL0 strobe |
| osc0_rdy_i | input | 1 | Oscillator 0 ready |
| pll_lock_i | input | NUM_PLL | PLL lock flags; bit 0 is PLL0 ready |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 1 | 0 = source code, 1 = divider word |
| cfg_wdata_i | input | 32 | Write data |
| sleep_lvl_i | input | 2 | Sleep depth 0..3 |
| mod_mask_i | input | 4*MODS | Per-module mask, 1 = gated |
| dom_en_o | output | 4 | Domain enables: CPU, HSB, PBA, PBB |
| mod_en_o | output | 4*MODS | Per-module enables |
| lock_irq_o | output | NUM_PLL | Lock rising-edge interrupt strobes |
| act_src_o | output | 2 | Active source code |
| act_div_o | output | 32 | Active divider word |

## Verification
The sharpest overlap is a divider write that arrives in the very cycle the prescaler wraps. In that cycle the write path loads the pending register while the wrap path copies pending into active. The bench produces this case right after reset by issuing exactly 255 main ticks, then asserting the write together with the 256th tick. It judges the result from `act_div_o` one cycle later: the new word must already be active. A second write, made while ticks are frozen, must stay pending until ticks resume.

// File: rtl/sck_pkg.sv
package sck_pkg;
  localparam int NDOM  = 4;
  localparam int PRE_W = 8;
  localparam int TAP_W = $clog2(PRE_W);
  localparam int EXP_W = TAP_W + 1;
  localparam int D_CPU = 0;
  localparam int D_HSB = 1;
  localparam int D_PBA = 2;
  localparam int D_PBB = 3;

  typedef enum logic [1:0] {
    SRC_SLOW = 2'd0,
    SRC_OSC0 = 2'd1,
    SRC_PLL0 = 2'd2,
    SRC_RSVD = 2'd3
  } src_e;

  function automatic logic [EXP_W-1:0] div_exp(input logic [7:0] b);
    return b[7] ? ({1'b0, b[TAP_W-1:0]} + EXP_W'(1)) : '0;
  endfunction

  function automatic logic rule_ok(input logic [31:0] w);
    return (div_exp(w[8*D_CPU +: 8]) <= div_exp(w[8*D_PBA +: 8])) &&
           (div_exp(w[8*D_CPU +: 8]) <= div_exp(w[8*D_PBB +: 8]));
  endfunction

  function automatic logic [1:0] sleep_thr(input int d);
    return (d == D_CPU) ? 2'd1 : (d == D_HSB) ? 2'd2 : 2'd3;
  endfunction
endpackage

// File: rtl/sck_prescaler.sv
module sck_prescaler
  import sck_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  output logic [PRE_W-1:0] tap_hit_o,
  output logic             wrap_o
);
  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  for (genvar n = 0; n < PRE_W; n++) begin : g_tap
    assign tap_hit_o[n] = tick_i & (&cnt_q[n:0]);
  end
  assign wrap_o = tap_hit_o[PRE_W-1];

  // R6
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (cnt_q == '0));
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/sck_cfg.sv
module sck_cfg
  import sck_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we_i,
  input  logic        addr_i,
  input  logic [31:0] wdata_i,
  input  logic        osc0_rdy_i,
  input  logic        pll0_rdy_i,
  input  logic        wrap_i,
  output src_e        act_src_o,
  output logic [31:0] act_div_o
);
  src_e        pend_src_q, act_src_q, nxt_src, req_src;
  logic [31:0] pend_div_q, act_div_q, nxt_div;
  logic        src_ok, div_ok;

  always_comb begin
    req_src = src_e'(wdata_i[1:0]);
    src_ok  = we_i && !addr_i &&
              ((req_src == SRC_SLOW) ||
               (req_src == SRC_OSC0 && osc0_rdy_i) ||
               (req_src == SRC_PLL0 && pll0_rdy_i));
    div_ok  = we_i && addr_i && rule_ok(wdata_i);
    nxt_src = src_ok ? req_src : pend_src_q;
    nxt_div = div_ok ? wdata_i : pend_div_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_src_q <= SRC_SLOW;
      act_src_q  <= SRC_SLOW;
      pend_div_q <= '0;
      act_div_q  <= '0;
    end else begin
      pend_src_q <= nxt_src;
      pend_div_q <= nxt_div;
      if (wrap_i) begin
        act_src_q <= nxt_src;
        act_div_q <= nxt_div;
      end
    end
  end

  assign act_src_o = act_src_q;
  assign act_div_o = act_div_q;

  // R6
  apply_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap_i |=> ($stable(act_div_q) && $stable(act_src_q)));
  // R5
  cpu_not_slower_chk: assert property (@(posedge clk) disable iff (rst)
    rule_ok(act_div_q));
  // R3
  no_rsvd_src_chk: assert property (@(posedge clk) disable iff (rst)
    act_src_q != SRC_RSVD);
endmodule

// File: rtl/sck_dom_gate.sv
module sck_dom_gate
  import sck_pkg::*;
#(
  parameter int MODS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [PRE_W-1:0] tap_hit_i,
  input  logic             div_en_i,
  input  logic [TAP_W-1:0] div_tap_i,
  input  logic             stop_i,
  input  logic [MODS-1:0]  mask_i,
  output logic             dom_o,
  output logic [MODS-1:0]  mod_o
);
  logic pulse;
  logic dom_q;
  logic [MODS-1:0] mod_q;

  assign pulse = (div_en_i ? tap_hit_i[div_tap_i] : tick_i) & ~stop_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      dom_q <= 1'b0;
      mod_q <= '0;
    end else begin
      dom_q <= pulse;
      mod_q <= {MODS{pulse}} & ~mask_i;
    end
  end

  assign dom_o = dom_q;
  assign mod_o = mod_q;

  // R7
  sleep_stop_chk: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> !dom_q);
  // R8
  mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((mod_q & $past(mask_i)) == '0));
  // R10
  no_tick_no_en_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> !dom_q);
endmodule

// File: rtl/sck_lock_irq.sv
module sck_lock_irq #(
  parameter int NUM_PLL = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_PLL-1:0] lock_i,
  output logic [NUM_PLL-1:0] irq_o
);
  logic [NUM_PLL-1:0] lock_q, irq_q;

  always_ff @(posedge clk) begin
    lock_q <= lock_i;
    if (rst) irq_q <= '0;
    else     irq_q <= lock_i & ~lock_q;
  end

  assign irq_o = irq_q;

  // R9
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_q != '0) |=> ((irq_q & $past(irq_q)) == '0));
endmodule

// File: rtl/sync_clk_gen.sv
module sync_clk_gen
  import sck_pkg::*;
#(
  parameter int NUM_PLL = 2,
  parameter int MODS    = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 slow_tick_i,
  input  logic                 osc0_tick_i,
  input  logic                 pll0_tick_i,
  input  logic                 osc0_rdy_i,
  input  logic [NUM_PLL-1:0]   pll_lock_i,
  input  logic                 cfg_we_i,
  input  logic                 cfg_addr_i,
  input  logic [31:0]          cfg_wdata_i,
  input  logic [1:0]           sleep_lvl_i,
  input  logic [NDOM*MODS-1:0] mod_mask_i,
  output logic [NDOM-1:0]      dom_en_o,
  output logic [NDOM*MODS-1:0] mod_en_o,
  output logic [NUM_PLL-1:0]   lock_irq_o,
  output logic [1:0]           act_src_o,
  output logic [31:0]          act_div_o
);
  src_e             act_src;
  logic [31:0]      act_div;
  logic             main_tick, wrap;
  logic [PRE_W-1:0] tap_hit;

  always_comb begin
    case (act_src)
      SRC_SLOW: main_tick = slow_tick_i;
      SRC_OSC0: main_tick = osc0_tick_i;
      SRC_PLL0: main_tick = pll0_tick_i;
      default:  main_tick = 1'b0;
    endcase
  end

  sck_cfg i_cfg (
    .clk(clk), .rst(rst), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .osc0_rdy_i(osc0_rdy_i),
    .pll0_rdy_i(pll_lock_i[0]), .wrap_i(wrap),
    .act_src_o(act_src), .act_div_o(act_div)
  );

  sck_prescaler i_pre (
    .clk(clk), .rst(rst), .tick_i(main_tick),
    .tap_hit_o(tap_hit), .wrap_o(wrap)
  );

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    sck_dom_gate #(.MODS(MODS)) i_gate (
      .clk(clk), .rst(rst), .tick_i(main_tick), .tap_hit_i(tap_hit),
      .div_en_i(act_div[8*d+7]), .div_tap_i(act_div[8*d +: TAP_W]),
      .stop_i(sleep_lvl_i >= sleep_thr(d)),
      .mask_i(mod_mask_i[d*MODS +: MODS]),
      .dom_o(dom_en_o[d]), .mod_o(mod_en_o[d*MODS +: MODS])
    );
  end

  sck_lock_irq #(.NUM_PLL(NUM_PLL)) i_irq (
    .clk(clk), .rst(rst), .lock_i(pll_lock_i), .irq_o(lock_irq_o)
  );

  assign act_src_o = act_src;
  assign act_div_o = act_div;

  // R2
  src_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (act_src == SRC_OSC0) |-> !(osc0_tick_i == 1'b0 && wrap));
endmodule

// File: tb/test_sync_clk_gen.sv
module test_sync_clk_gen;
  localparam int NP = 2;
  localparam int MD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slow_t = 1'b1, osc_t = 1'b0, pll_t = 1'b0, osc_rdy = 1'b0;
  logic [NP-1:0] lock = '0;
  logic we = 1'b0, addr = 1'b0;
  logic [31:0] wdata = '0;
  logic [1:0] slp = '0;
  logic [4*MD-1:0] mask = '0;
  logic [3:0] dom_en;
  logic [4*MD-1:0] mod_en;
  logic [NP-1:0] irq;
  logic [1:0] a_src;
  logic [31:0] a_div;

  int total = 0, bad = 0;
  int cnt[4];
  int mcnt[4*MD];

  always #5 clk = ~clk;

  sync_clk_gen #(.NUM_PLL(NP), .MODS(MD)) i_sync_clk_gen (
    .clk(clk), .rst(rst), .slow_tick_i(slow_t), .osc0_tick_i(osc_t),
    .pll0_tick_i(pll_t), .osc0_rdy_i(osc_rdy), .pll_lock_i(lock),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .sleep_lvl_i(slp), .mod_mask_i(mask), .dom_en_o(dom_en),
    .mod_en_o(mod_en), .lock_irq_o(irq), .act_src_o(a_src), .act_div_o(a_div)
  );

  // {accepted, divider word}
  localparam logic [32:0] VEC [7] = '{
    {1'b1, 32'h00000000},
    {1'b1, 32'h83810080},
    {1'b0, 32'h00810082},
    {1'b1, 32'h00878500},
    {1'b1, 32'h87878787},
    {1'b0, 32'h00878787},
    {1'b1, 32'h07070707}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bexp(input logic [7:0] b);
    return b[7] ? int'(b[2:0]) + 1 : 0;
  endfunction

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count(input int n);
    for (int d = 0; d < 4; d++) cnt[d] = 0;
    for (int b = 0; b < 4*MD; b++) mcnt[b] = 0;
    repeat (n) begin
      @(negedge clk);
      for (int d = 0; d < 4; d++) cnt[d] += int'(dom_en[d]);
      for (int b = 0; b < 4*MD; b++) mcnt[b] += int'(mod_en[b]);
    end
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] exp_div;
    waitn(4);
    // R1 reset state
    chk("R1 src", 32'(a_src), 0);
    chk("R1 div", a_div, 0);
    chk("R1 en", {12'd0, mod_en, dom_en}, 0);
    chk("R1 irq", 32'(irq), 0);

    // R6 write in the same cycle as the wrap: 255 ticks, then write on the 256th
    rst = 1'b0;
    waitn(255);
    we = 1'b1; addr = 1'b1; wdata = 32'h83838383;
    @(negedge clk); we = 1'b0;
    chk("R6 write at wrap", a_div, 32'h83838383);
    // R6 frozen ticks hold a pending write
    slow_t = 1'b0;
    wr(1'b1, 32'h0);
    waitn(20);
    chk("R6 held pending", a_div, 32'h83838383);
    slow_t = 1'b1;
    waitn(300);
    chk("R6 applied after wrap", a_div, 0);

    // R4 R5 vector walk
    exp_div = 32'h0;
    for (int v = 0; v < 7; v++) begin
      wr(1'b1, VEC[v][31:0]);
      if (VEC[v][32]) exp_div = VEC[v][31:0];
      waitn(300);
      chk("R5 accept/reject", a_div, exp_div);
      count(512);
      for (int d = 0; d < 4; d++)
        chk("R4 rate", 32'(cnt[d]), 32'(512 >> bexp(exp_div[8*d +: 8])));
    end

    // R3 illegal source selects
    wr(1'b0, 32'd1); waitn(300); chk("R3 osc0 not ready", 32'(a_src), 0);
    wr(1'b0, 32'd3); waitn(300); chk("R3 reserved code", 32'(a_src), 0);
    wr(1'b0, 32'd2); waitn(300); chk("R3 pll0 unlocked", 32'(a_src), 0);
    count(256); chk("R3 still slow", 32'(cnt[0]), 256);

    // R2 switch to oscillator 0
    osc_rdy = 1'b1;
    wr(1'b0, 32'd1); waitn(300);
    chk("R2 osc0 active", 32'(a_src), 1);
    osc_t = 1'b0;
    count(256); chk("R2 idle osc0", 32'(cnt[0]), 0);
    osc_t = 1'b1; waitn(2);
    count(512); chk("R2 osc0 ticks", 32'(cnt[0]), 512);
    // R6 deferred while source idle
    osc_t = 1'b0;
    wr(1'b0, 32'd0); waitn(50);
    chk("R6 src pending", 32'(a_src), 1);
    osc_t = 1'b1; waitn(300);
    chk("R6 src applied", 32'(a_src), 0);

    // R7 sleep levels
    for (int l = 1; l < 4; l++) begin
      slp = 2'(l); waitn(2);
      count(256);
      chk("R7 cpu", 32'(cnt[0]), 0);
      chk("R7 hsb", 32'(cnt[1]), (l >= 2) ? 0 : 256);
      chk("R7 pba", 32'(cnt[2]), (l >= 3) ? 0 : 256);
      chk("R7 pbb", 32'(cnt[3]), (l >= 3) ? 0 : 256);
    end
    slp = 2'd0;

    // R8 module masks
    mask = 16'hA5C3; waitn(2);
    count(256);
    for (int b = 0; b < 4*MD; b++)
      chk("R8 mask", 32'(mcnt[b]), mask[b] ? 0 : 256);
    mask = '0;

    // R10 one-cycle latency
    slow_t = 1'b0; waitn(3);
    chk("R10 idle", 32'(dom_en[0]), 0);
    slow_t = 1'b1;
    @(negedge clk); slow_t = 1'b0;
    chk("R10 next cycle", 32'(dom_en[0]), 1);
    @(negedge clk);
    chk("R10 single", 32'(dom_en[0]), 0);
    slow_t = 1'b1;

    // R9 lock interrupt
    lock[1] = 1'b1;
    @(negedge clk); chk("R9 rise", 32'(irq), 32'b10);
    @(negedge clk); chk("R9 one cycle", 32'(irq), 0);
    waitn(5); chk("R9 steady", 32'(irq), 0);
    lock[1] = 1'b0;
    @(negedge clk); chk("R9 fall", 32'(irq), 0);
    lock[0] = 1'b1;
    @(negedge clk); chk("R9 pll0 rise", 32'(irq), 32'b01);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule